// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data between one narrow port A and a pair of wide-side ports, 1B and 2B, each as wide as A. Going from A toward B, two A words arriving on successive clocks are gathered and then presented together, one on 1B and one on 2B. Going from B toward A, a select input picks one of the two B words, and that word is registered onto A. All storage is clocked on the rising edge of `clk`.

The 1B side has two register stages. The select input controls them. With `sel` low, an edge loads the A word into the first stage. With `sel` high, an edge moves the first stage into the second stage, and the second stage drives 1B. The 2B side has one register, which captures A on edges where `sel` is high.

Drivers that would be tri-state in a pad ring are modelled here as a data output and a drive-enable for each port. The direction input passes through a two-state machine, with states `XFER_TO_A` and `XFER_TO_B`, so a bus turnaround always lines up with a clock edge:
- `TO_A_STAY` is taken when `dir` is sampled low in `XFER_TO_A`.
- `GO_TO_B` is taken when `dir` is sampled high in `XFER_TO_A`.
- `TO_B_STAY` is taken when `dir` is sampled high in `XFER_TO_B`.
- `GO_TO_A` is taken when `dir` is sampled low in `XFER_TO_B`.

The active-low `oe_n` acts on the drive enables without waiting for a clock.

Top module: `xchg_bus_exchanger`

## Requirements
- R1: While `rst` is sampled high on an edge, all data registers clear to zero and the direction state becomes `XFER_TO_A`. After reset with `oe_n` low, `a_drive_en`=1, `b1_drive_en`=0, `b2_drive_en`=0, and every data output reads zero.
- R2: On an edge with `sel`=0, the first 1B stage loads `a_in`, and `b1_out` keeps its value.
- R3: On an edge with `sel`=1, `b1_out` takes the value the first 1B stage held before that edge. A word therefore reaches 1B after one `sel`=0 edge followed by one `sel`=1 edge.
- R4: On an edge with `sel`=1, `b2_out` takes `a_in`. On an edge with `sel`=0, `b2_out` is unchanged.
- R5: On every edge, `a_out` takes `b1_in` when `sel`=1 and `b2_in` when `sel`=0.
- R6: The direction state after an edge equals `dir` sampled at that edge (1 = `XFER_TO_B`, 0 = `XFER_TO_A`). A change on `dir` between edges does not change the drive enables.
- R7: When `oe_n`=1, all three drive enables are 0 in that same cycle, with no clock edge needed.
- R8: When `oe_n`=0, state `XFER_TO_B` gives `b1_drive_en`=`b2_drive_en`=1 and `a_drive_en`=0, and state `XFER_TO_A` gives `a_drive_en`=1 and both B enables 0.
- R9: The data registers on both paths capture as R2 to R5 describe, whatever the direction state and `oe_n` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low output enable for all drivers |
| dir | input | 1 | Requested direction, 1 = toward B; registered |
| sel | input | 1 | 1B pipeline advance / B word select |
| a_in | input | WIDTH | Narrow port data as seen on the pins |
| a_out | output | WIDTH | Registered B word for the narrow port |
| a_drive_en | output | 1 | Narrow port driver enable |
| b1_in | input | WIDTH | 1B data as seen on the pins |
| b1_out | output | WIDTH | Second 1B pipeline stage |
| b1_drive_en | output | 1 | 1B driver enable |
| b2_in | input | WIDTH | 2B data as seen on the pins |
| b2_out | output | WIDTH | 2B storage register |
| b2_drive_en | output | 1 | 2B driver enable |

## Verification
The bench sweeps every combination of `sel`, `dir` and `oe_n` against data words generated arithmetically. It compares each output after each edge with a model built only from the requirements.

Three corner cases get particular attention:
- Back-to-back `sel`=1 edges must copy the same first-stage word into 1B again and must not pull `a_in` through. A design that shortened the 1B path to one stage would show the wrong word there.
- A `dir` change between edges must leave the enables alone until the next edge. A design that steered from the raw pin would swap drivers early.
- Raising `oe_n` must drop every enable at once. A design that gated it with the clock would keep driving for a cycle.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

    // Registered bus direction; encoding matches the dir pin value
    typedef enum logic {
        XFER_TO_A = 1'b0,
        XFER_TO_B = 1'b1
    } xfer_dir_e;

endpackage

// File: rtl/xchg_dir_fsm.sv
module xchg_dir_fsm
    import xchg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      dir,
    input  logic      oe_n,
    output xfer_dir_e state,
    output logic      a_en,
    output logic      b_en
);

    xfer_dir_e nxt;

    // Next-state logic: every transition is named in the brief
    always_comb begin
        nxt = state;
        unique case (state)
            XFER_TO_A: nxt = dir ? XFER_TO_B : XFER_TO_A;  // GO_TO_B / TO_A_STAY
            XFER_TO_B: nxt = dir ? XFER_TO_B : XFER_TO_A;  // TO_B_STAY / GO_TO_A
            default:   nxt = XFER_TO_A;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= XFER_TO_A;
        else     state <= nxt;
    end

    // Output decode: oe_n gates combinationally
    always_comb begin
        a_en = 1'b0;
        b_en = 1'b0;
        unique case (state)
            XFER_TO_A: a_en = !oe_n;
            XFER_TO_B: b_en = !oe_n;
            default: begin
                a_en = 1'b0;
                b_en = 1'b0;
            end
        endcase
    end

    // R6: state follows the sampled dir pin one edge later
    a_r6_dir_registered: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (state == xfer_dir_e'($past(dir))));

    // R7: disabled output enable releases both sides
    a_r7_oe_releases: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!a_en && !b_en));

    // R8: never both sides at once
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(a_en && b_en));

endmodule

// File: rtl/xchg_wide_path.sv
module xchg_wide_path #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] b1_q,
    output logic [WIDTH-1:0] b2_q
);

    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] stage1;

    // First 1B stage loads on sel low
    always_ff @(posedge clk) begin
        if (rst)       stage1 <= ZERO;
        else if (!sel) stage1 <= a_in;
    end

    // Second 1B stage and the 2B register advance on sel high
    always_ff @(posedge clk) begin
        if (rst) begin
            b1_q <= ZERO;
            b2_q <= ZERO;
        end else if (sel) begin
            b1_q <= stage1;
            b2_q <= a_in;
        end
    end

    // R2: a sel-low edge leaves 1B untouched
    a_r2_b1_hold: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(b1_q));

    // R3: a sel-high edge moves the first stage forward
    a_r3_b1_advance: assert property (@(posedge clk) disable iff (rst)
        sel |=> (b1_q == $past(stage1)));

    // R4: 2B captures A on sel high and holds otherwise
    a_r4_b2_capture: assert property (@(posedge clk) disable iff (rst)
        sel |=> (b2_q == $past(a_in)));
    a_r4_b2_hold: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(b2_q));

endmodule

// File: rtl/xchg_narrow_path.sv
module xchg_narrow_path #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic [WIDTH-1:0] b1_in,
    input  logic [WIDTH-1:0] b2_in,
    output logic [WIDTH-1:0] a_q
);

    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] pick;

    always_comb begin
        pick = sel ? b1_in : b2_in;
    end

    always_ff @(posedge clk) begin
        if (rst) a_q <= ZERO;
        else     a_q <= pick;
    end

    // R5: the chosen B word appears on A after the edge
    a_r5_pick_b1: assert property (@(posedge clk) disable iff (rst)
        sel |=> (a_q == $past(b1_in)));
    a_r5_pick_b2: assert property (@(posedge clk) disable iff (rst)
        !sel |=> (a_q == $past(b2_in)));

endmodule

// File: rtl/xchg_bus_exchanger.sv
module xchg_bus_exchanger
    import xchg_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive_en,
    input  logic [WIDTH-1:0] b1_in,
    output logic [WIDTH-1:0] b1_out,
    output logic             b1_drive_en,
    input  logic [WIDTH-1:0] b2_in,
    output logic [WIDTH-1:0] b2_out,
    output logic             b2_drive_en
);

    xfer_dir_e dir_state;
    logic      a_en;
    logic      b_en;

    xchg_dir_fsm u_dir (
        .clk   (clk),
        .rst   (rst),
        .dir   (dir),
        .oe_n  (oe_n),
        .state (dir_state),
        .a_en  (a_en),
        .b_en  (b_en)
    );

    // Data registers run regardless of direction (R9)
    xchg_wide_path #(.WIDTH(WIDTH)) u_wide (
        .clk  (clk),
        .rst  (rst),
        .sel  (sel),
        .a_in (a_in),
        .b1_q (b1_out),
        .b2_q (b2_out)
    );

    xchg_narrow_path #(.WIDTH(WIDTH)) u_narrow (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .b1_in (b1_in),
        .b2_in (b2_in),
        .a_q   (a_out)
    );

    always_comb begin
        a_drive_en  = a_en;
        b1_drive_en = b_en;
        b2_drive_en = b_en;
    end

    // R8: with oe_n low, the B side drives exactly in XFER_TO_B
    a_r8_b_side: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (b1_drive_en == (dir_state == XFER_TO_B)));

    // R1: first cycle after reset releases B
    a_r1_reset_dir: assert property (@(posedge clk)
        $past(rst) |-> (dir_state == XFER_TO_A));

endmodule

// File: tb/xchg_bus_exchanger_bench.sv
module xchg_bus_exchanger_bench;

    localparam int W      = 18;
    localparam int CLK_NS = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         oe_n = 1'b0;
    logic         dir = 1'b0;
    logic         sel = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b1_in = '0;
    logic [W-1:0] b2_in = '0;
    logic [W-1:0] a_out;
    logic [W-1:0] b1_out;
    logic [W-1:0] b2_out;
    logic         a_drive_en;
    logic         b1_drive_en;
    logic         b2_drive_en;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Model state, built from the requirements
    logic [W-1:0] m_s1, m_b1, m_b2, m_a;
    logic         m_dir;

    always #(CLK_NS/2) clk = ~clk;

    xchg_bus_exchanger #(.WIDTH(W)) u_xchg_bus_exchanger (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .sel(sel),
        .a_in(a_in), .a_out(a_out), .a_drive_en(a_drive_en),
        .b1_in(b1_in), .b1_out(b1_out), .b1_drive_en(b1_drive_en),
        .b2_in(b2_in), .b2_out(b2_out), .b2_drive_en(b2_drive_en)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_en(input string req);
        check({req, " a_drive_en"},  W'(a_drive_en),  W'(!oe_n && !m_dir));
        check({req, " b1_drive_en"}, W'(b1_drive_en), W'(!oe_n && m_dir));
        check({req, " b2_drive_en"}, W'(b2_drive_en), W'(!oe_n && m_dir));
    endtask

    // One edge: update model from the applied inputs, then compare at negedge
    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_s1 = '0; m_b1 = '0; m_b2 = '0; m_a = '0; m_dir = 1'b0;
        end else begin
            if (sel) begin
                m_b1 = m_s1;      // R3
                m_b2 = a_in;      // R4
            end else begin
                m_s1 = a_in;      // R2
            end
            m_a   = sel ? b1_in : b2_in;  // R5
            m_dir = dir;                  // R6
        end
        @(negedge clk);
        check("R2/R3 b1_out (R9)", b1_out, m_b1);
        check("R4 b2_out (R9)",    b2_out, m_b2);
        check("R5 a_out (R9)",     a_out,  m_a);
        check_en("R8");
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_s1 = '0; m_b1 = '0; m_b2 = '0; m_a = '0; m_dir = 1'b0;
        @(negedge clk);
        tick();
        tick();
        rst = 1'b0;
        // R1: reset state
        check("R1 a_out", a_out, '0);
        check("R1 b1_out", b1_out, '0);
        check("R1 b2_out", b2_out, '0);
        check("R1 a_drive_en", W'(a_drive_en), W'(1));
        check("R1 b1_drive_en", W'(b1_drive_en), W'(0));

        // R3: two edges to reach 1B
        a_in = W'(18'h2A5A5); sel = 1'b0; tick();
        a_in = W'(18'h11111); sel = 1'b1; tick();
        check("R3 word after two edges", b1_out, W'(18'h2A5A5));
        check("R4 word after sel high", b2_out, W'(18'h11111));
        // back-to-back sel high repeats the same first-stage word
        a_in = W'(18'h33333); tick();
        check("R3 repeat advance", b1_out, W'(18'h2A5A5));

        // Sweep control combinations with arithmetic data
        for (int i = 0; i < 512; i++) begin
            sel   = i[0];
            dir   = i[1];
            oe_n  = i[2];
            a_in  = W'((i * 40503 + 7) & 18'h3FFFF);
            b1_in = W'((i * 977) ^ 18'h15A5A);
            b2_in = W'(~(i * 131 + 3));
            #1;
            // R7: oe_n acts before any edge
            check_en("R7");
            tick();
        end

        // R6: dir change between edges has no effect until the edge
        oe_n = 1'b0; dir = 1'b0; tick();
        dir = 1'b1; #1;
        check("R6 before edge a_drive_en", W'(a_drive_en), W'(1));
        check("R6 before edge b1_drive_en", W'(b1_drive_en), W'(0));
        tick();
        check("R6 after edge b1_drive_en", W'(b1_drive_en), W'(1));
        // R7 at the ports in XFER_TO_B
        oe_n = 1'b1; #1;
        check("R7 oe_n high b2_drive_en", W'(b2_drive_en), W'(0));
        check("R7 oe_n high a_drive_en", W'(a_drive_en), W'(0));

        // R1: reset mid-run clears everything again
        rst = 1'b1; oe_n = 1'b0; tick();
        rst = 1'b0; dir = 1'b0;
        check("R1 re-reset b1_out", b1_out, '0);
        check("R1 re-reset a_drive_en", W'(a_drive_en), W'(1));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule